// File: doc/BRIEF.md
# Serial Configuration Stream Parser

This block sits at the front of a configuration loader and takes a serial bitstream, one bit per configuration clock. While it waits for work, high bits on the serial input are idle filler. A low bit begins a four-bit header whose value must be 0010. The header is followed by a 24-bit count of configuration clocks. Both the header and the count travel on to any later device in a daisy chain through a registered serial output. Once the count is loaded, a down-counter spends one step per clock and raises a flag when it reaches zero.

The block then reads a fixed number of frames of its own. Each frame is a single low start bit, a parameterised number of data bits, and a four-bit check field. A frame with a correct check is handed to the frame-write side as one word with a one-cycle valid strobe. A bad start bit or a bad check field stops loading and holds the initialisation-failure output high until reset. One chosen data bit of the first frame sets the fast-clock request for the external clock generator. While the block's own frames pass, the serial output stays high. After the last frame it follows the input again, so that later data reaches the next device.

Top module: `cfg_stream_parser`

## Requirements
- R1: During and after reset, `dout` is 1, and `frm_valid`, `init_low`, `fast_clk_sel` and `length_done` are 0.
- R2: Before the header, a 1 on `din` is ignored. A 0 starts the header, and the next three bits must be 0, 1, 0 in that order. Any other bit ends the attempt and the block goes back to hunting for the header.
- R3: The 24 bits after the header are the length count, most significant bit first. They are loaded on the clock that takes the last length bit. The counter then falls by one on every later clock. `length_done` is 1 once the counter reaches zero and stays 1. A zero length gives `length_done` right after the load.
- R4: `dout` is `din` delayed by one clock while the block hunts, reads the header and reads the length. It is 1 from the first start bit until the end of the last check field, and it stays 1 after an error.
- R5: A frame is one start bit of 0, then FRAME_BITS data bits, then the check field 0110 (leftmost bit first). The first data bit lands in the MSB of `frm_data`. `frm_valid` pulses for one clock, in the cycle after the last check bit.
- R6: If a check field differs from 0110, `init_low` rises after the last check bit. It stays high until reset, and no later frame produces `frm_valid`.
- R7: A 1 where a start bit is expected is also a frame error, with the same effect as R6.
- R8: Data bit SEL_POS of the first frame (0 = first data bit) is copied to `fast_clk_sel` in the next cycle. Data bits of later frames leave it unchanged.
- R9: After FRAMES good frames, `dout` follows `din` again, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 1 | Serial configuration data |
| dout | output | 1 | Serial data toward the next device in the chain |
| frm_data | output | FRAME_BITS | Last accepted frame word |
| frm_valid | output | 1 | One-cycle strobe for a new frame word |
| init_low | output | 1 | Sticky frame-error indication |
| fast_clk_sel | output | 1 | Request for the eight-times configuration clock |
| length_done | output | 1 | Length counter has reached zero |

## Verification
The bench builds the parser with 8-bit frames, three frames per device and the clock-select bit at data position 2. This keeps each frame to 13 clocks, so one short run covers a full load and the return to pass-through. A length of 40 makes the counter reach zero during the pass-through bits, which places the zero crossing exactly inside the run. A zero length covers the immediate case. Separate runs after reset cover a bad check field, a bad start bit, and a false header that breaks off after two bits.

// File: rtl/cfg_parse_pkg.sv
package cfg_parse_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_HDR,
    ST_LEN,
    ST_START,
    ST_DATA,
    ST_CHK,
    ST_PASS,
    ST_HALT
  } parse_state_t;

  localparam logic [3:0] HDR_CODE = 4'b0010;
  localparam logic [3:0] CHK_CODE = 4'b0110;

  // Expected header bit at position idx (0 = first received).
  function automatic logic hdr_bit(input logic [1:0] idx);
    return HDR_CODE[3 - idx];
  endfunction

  // Check field is complete when three stored bits plus the newest bit form the code.
  function automatic logic chk_match(input logic [2:0] held, input logic newest);
    return {held, newest} == CHK_CODE;
  endfunction

endpackage

// File: rtl/cfg_len_counter.sv
module cfg_len_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;
  logic         armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cnt   <= load_val;
      armed <= 1'b1;
    end else if (armed && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = armed && (cnt == '0);

endmodule

// File: rtl/cfg_frame_shift.sv
module cfg_frame_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  input  logic         commit,
  output logic [W-1:0] data,
  output logic         valid
);

  logic [W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= commit;
      if (shift_en) shreg <= {shreg[W-2:0], bit_in};
      if (commit)   data  <= shreg;
    end
  end

endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
  import cfg_parse_pkg::*;
#(
  parameter int LEN_BITS   = 24,
  parameter int FRAME_BITS = 16,
  parameter int FRAMES     = 4,
  parameter int SEL_POS    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  din,
  output logic                  dout,
  output logic [FRAME_BITS-1:0] frm_data,
  output logic                  frm_valid,
  output logic                  init_low,
  output logic                  fast_clk_sel,
  output logic                  length_done
);

  localparam int MAXF = (LEN_BITS > FRAME_BITS) ? LEN_BITS : FRAME_BITS;
  localparam int CW   = $clog2(MAXF + 1);
  localparam int FW   = $clog2(FRAMES + 1);

  parse_state_t        state, state_n;
  logic [CW-1:0]       bit_cnt;
  logic [FW-1:0]       frm_idx;
  logic [2:0]          chk_sh;
  logic [LEN_BITS-1:0] len_sh;
  logic                dout_q, err_q, sel_q;

  // Named internal events
  logic fwd_now, hold_dout;
  logic ev_len_loaded, ev_frame_ok, ev_frame_bad, ev_sel_bit;
  logic last_field_bit;

  assign fwd_now   = (state == ST_HUNT) || (state == ST_HDR) ||
                     (state == ST_LEN)  || (state == ST_PASS);
  assign hold_dout = !fwd_now;

  assign ev_len_loaded  = (state == ST_LEN) && (bit_cnt == CW'(LEN_BITS - 1));
  assign last_field_bit = (state == ST_CHK) && (bit_cnt == CW'(3));
  assign ev_frame_ok    = last_field_bit && chk_match(chk_sh, din);
  assign ev_frame_bad   = (last_field_bit && !chk_match(chk_sh, din)) ||
                          ((state == ST_START) && din);
  assign ev_sel_bit     = (state == ST_DATA) && (frm_idx == '0) &&
                          (bit_cnt == CW'(SEL_POS));

  always_comb begin
    state_n = state;
    unique case (state)
      ST_HUNT:  if (!din) state_n = ST_HDR;
      ST_HDR:   if (din != hdr_bit(bit_cnt[1:0])) state_n = ST_HUNT;
                else if (bit_cnt == CW'(3))         state_n = ST_LEN;
      ST_LEN:   if (ev_len_loaded) state_n = ST_START;
      ST_START: state_n = din ? ST_HALT : ST_DATA;
      ST_DATA:  if (bit_cnt == CW'(FRAME_BITS - 1)) state_n = ST_CHK;
      ST_CHK:   if (ev_frame_bad) state_n = ST_HALT;
                else if (ev_frame_ok)
                  state_n = (frm_idx == FW'(FRAMES - 1)) ? ST_PASS : ST_START;
      ST_PASS:  state_n = ST_PASS;
      ST_HALT:  state_n = ST_HALT;
      default:  state_n = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      bit_cnt <= '0;
      frm_idx <= '0;
      chk_sh  <= '0;
      len_sh  <= '0;
      dout_q  <= 1'b1;
      err_q   <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      state  <= state_n;
      dout_q <= fwd_now ? din : 1'b1;
      if (ev_frame_bad) err_q <= 1'b1;
      if (ev_sel_bit)   sel_q <= din;
      if (state == ST_LEN) len_sh <= {len_sh[LEN_BITS-2:0], din};
      if (state == ST_CHK) chk_sh <= {chk_sh[1:0], din};
      if (ev_frame_ok) frm_idx <= frm_idx + 1'b1;
      // Bit counter restarts on every change of field
      if (state_n != state) bit_cnt <= (state == ST_HUNT) ? CW'(1) : '0;
      else if (state != ST_HUNT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  cfg_len_counter #(.W(LEN_BITS)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_len_loaded),
    .load_val ({len_sh[LEN_BITS-2:0], din}),
    .done     (length_done)
  );

  cfg_frame_shift #(.W(FRAME_BITS)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (state == ST_DATA),
    .bit_in   (din),
    .commit   (ev_frame_ok),
    .data     (frm_data),
    .valid    (frm_valid)
  );

  assign dout         = dout_q;
  assign init_low     = err_q;
  assign fast_clk_sel = sel_q;

endmodule

// File: rtl/cfg_stream_parser_chk.sv
module cfg_stream_parser_chk (
  input logic clk,
  input logic rst_n,
  input logic dout,
  input logic frm_valid,
  input logic init_low,
  input logic fast_clk_sel,
  input logic length_done,
  input logic hold_dout,
  input logic ev_sel_bit,
  input logic ev_frame_bad
);

  p_init_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_low |=> init_low);

  p_no_valid_after_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_low |-> !frm_valid);

  p_err_raises_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_bad |=> init_low);

  p_dout_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_dout |=> dout);

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);

  p_sel_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fast_clk_sel) |-> $past(ev_sel_bit));

  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    length_done |=> length_done);

endmodule

bind cfg_stream_parser cfg_stream_parser_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dout         (dout),
  .frm_valid    (frm_valid),
  .init_low     (init_low),
  .fast_clk_sel (fast_clk_sel),
  .length_done  (length_done),
  .hold_dout    (hold_dout),
  .ev_sel_bit   (ev_sel_bit),
  .ev_frame_bad (ev_frame_bad)
);

// File: tb/cfg_stream_parser_tb.sv
module cfg_stream_parser_tb;

  localparam int LB = 24;
  localparam int FB = 8;
  localparam int NF = 3;
  localparam int SP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b1;
  logic dout, frm_valid, init_low, fast_clk_sel, length_done;
  logic [FB-1:0] frm_data;

  int checks = 0;
  int fails  = 0;
  int since_load = 0;
  bit loaded_tb = 1'b0;
  int len_cur = 0;
  logic [FB-1:0] exp_q[$];

  always #5 clk = ~clk;

  cfg_stream_parser #(.LEN_BITS(LB), .FRAME_BITS(FB), .FRAMES(NF), .SEL_POS(SP)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .dout(dout), .frm_data(frm_data),
    .frm_valid(frm_valid), .init_low(init_low), .fast_clk_sel(fast_clk_sel),
    .length_done(length_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: compares produced frame words against the scoreboard queue
  always @(posedge clk) begin
    #2;
    if (rst_n && frm_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5/R6: actual unexpected frame %0h expected none", frm_data);
      end else begin
        logic [FB-1:0] e;
        e = exp_q.pop_front();
        if (frm_data !== e) begin
          fails++;
          $display("FAIL R5: actual %0h expected %0h", frm_data, e);
        end
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    din = 1'b1;
    loaded_tb = 1'b0;
    since_load = 0;
    exp_q.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 dout", dout, 1);
    chk("R1 frm_valid", frm_valid, 0);
    chk("R1 init_low", init_low, 0);
    chk("R1 fast_clk_sel", fast_clk_sel, 0);
    chk("R1 length_done", length_done, 0);
  endtask

  // Drive one bit, wait for its edge, check dout and the length counter
  task automatic send(input logic b, input bit fwd, input bit load_now);
    din = b;
    @(posedge clk);
    #1;
    if (load_now) begin
      loaded_tb = 1'b1;
      since_load = 0;
    end else if (loaded_tb) since_load++;
    chk(fwd ? "R4/R9 dout follows" : "R4 dout held", dout, fwd ? b : 1'b1);
    chk("R3 length_done", length_done, loaded_tb && (since_load >= len_cur));
  endtask

  task automatic send_header_len(input int len);
    len_cur = len;
    send(0, 1, 0); send(0, 1, 0); send(1, 1, 0); send(0, 1, 0);
    for (int i = LB - 1; i >= 0; i--) send(len[i], 1, i == 0);
  endtask

  task automatic send_frame(input logic [FB-1:0] d, input logic [3:0] c, input bit expect_ok);
    send(0, 0, 0);
    for (int i = FB - 1; i >= 0; i--) send(d[i], 0, 0);
    for (int i = 3; i >= 0; i--) begin
      if (i == 0 && expect_ok) exp_q.push_back(d);
      send(c[i], 0, 0);
    end
    chk("R5 valid strobe", frm_valid, expect_ok);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // Run 1: idle, broken header, full load, pass-through
    do_reset();
    for (int i = 0; i < 5; i++) send(1, 1, 0);         // R2 idle ignored
    send(0, 1, 0); send(1, 1, 0);                      // R2 broken header
    send(1, 1, 0);
    chk("R2 no load yet", length_done, 0);
    send_header_len(40);
    chk("R8 slow before select", fast_clk_sel, 0);
    send_frame(8'h20, 4'b0110, 1);
    chk("R8 select taken", fast_clk_sel, 1);
    send_frame(8'h5A, 4'b0110, 1);
    send_frame(8'hC3, 4'b0110, 1);
    chk("R8 later frames ignored", fast_clk_sel, 1);
    chk("R6 no error", init_low, 0);
    send(1, 1, 0); send(0, 1, 0); send(0, 1, 0); send(1, 1, 0); // R9
    chk("R5 all frames seen", exp_q.size(), 0);

    // Run 2: zero length, bad check field
    do_reset();
    send(1, 1, 0);
    send_header_len(0);
    send_frame(8'hFF, 4'b0111, 0);
    chk("R6 init_low raised", init_low, 1);
    send_frame(8'h33, 4'b0110, 0);                     // R6 no further frames
    send(0, 0, 0); send(1, 0, 0);
    chk("R6 init_low held", init_low, 1);

    // Run 3: bad start bit
    do_reset();
    send_header_len(5);
    chk("R7 before error", init_low, 0);
    send(1, 0, 0);
    chk("R7 start bit error", init_low, 1);
    send_frame(8'h11, 4'b0110, 0);
    chk("R7 no frame", frm_valid, 0);
    chk("R5 queue empty", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule